// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM with 512K locations of 8 bits. The host raises a single-cycle request carrying a 19-bit address, a write flag and a write byte. The sequencer then drives the memory's active-low chip select, output enable and write enable, the address and the write data. It returns a one-clock acknowledge, and on reads the byte it fetched. The data bus is shared in both directions. The block drives it through a separate output value and an output-enable pin, so the pad ring can build the tri-state buffer.

Every timing limit of the memory is a parameter in nanoseconds, together with the clock period. Each phase lasts the ceiling of its limit divided by the period, and never less than one clock. A read holds chip select and output enable low long enough for address access and the read cycle. A write first waits with output enable high until the memory's outputs have released the bus. It then drives the data and holds chip select and write enable low together for the write pulse. It keeps the data and address steady for a recovery interval that completes the write cycle.

Top module: `asram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, chip select, output enable and write enable are high (inactive), the data drivers are off, and the acknowledge is low.
- R2: A read holds chip select and output enable low with write enable high for exactly RD_CYC consecutive clocks, where RD_CYC is the larger of ceil(address-access ns / clock ns) and ceil(read-cycle ns / clock ns), with a minimum of 1 (18 at the defaults).
- R3: The byte present on the input data bus during the last clock of the read phase is returned on the read-data output while the acknowledge is high, and the read-data output keeps that value through any following writes until the next read completes.
- R4: Before a write enables its data drivers, output enable has been high for at least TURN_CYC clocks, where TURN_CYC = ceil(output-disable ns / clock ns) (7 at the defaults).
- R5: A write holds chip select and write enable low together for exactly WP_CYC consecutive clocks, where WP_CYC is the largest of the ceilings for write pulse, chip-select-to-end-of-write and data setup (15 at the defaults). The data drivers stay on and the write byte stays stable throughout.
- R6: The memory address does not change while chip select is low.
- R7: After the write pulse ends, the data drivers and the write byte are kept for REC_CYC clocks, where REC_CYC = max(1, ceil(write-cycle ns / clock ns) - WP_CYC) (3 at the defaults).
- R8: The acknowledge is high for exactly one clock. It is first seen RD_CYC clock edges after the edge that accepts a read, and TURN_CYC + WP_CYC + REC_CYC edges (25 at the defaults) after the edge that accepts a write.
- R9: A request is accepted only while the block is idle. Request inputs that are presented or changed during an access have no effect on that access and produce no extra acknowledge.
- R10: Output enable and write enable are never low together, and the data drivers are never on while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Byte to write |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte from the last completed read |
| mem_addr | output | 19 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data value driven toward the memory |
| mem_dq_oe | output | 1 | 1 = drive mem_dq_o onto the shared bus |
| mem_dq_i | input | 8 | Data sampled from the shared bus |

## Verification
The bound checker watches every clock for the properties that need no knowledge of the host's intent. These are exclusive output-enable and write-enable, no driver contention, a steady address under chip select, a stable write byte during the pulse, a single-clock acknowledge, and the output-enable-high interval before the drivers turn on. The exact phase lengths, the acknowledge latency, and the data that actually reaches the memory and comes back can only be shown by the bench. It uses a behavioural memory model that commits a byte at the end of each chip-select and write-enable overlap. It also scrambles and re-pulses the request inputs mid-access and compares every returned byte against its own record of what was written.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_TURN   = 3'd2,
        PH_WPULSE = 3'd3,
        PH_WREC   = 3'd4,
        PH_ACK    = 3'd5
    } phase_e;

    // Pin-level control bits, all registered before leaving the block
    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
        logic ack;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ack: 1'b0};

    // Nanosecond limit to whole clocks, rounded up, never below one
    function automatic int ns2cyc(input int lim_ns, input int clk_ns);
        int c;
        c = (lim_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int AW       = 19,
    parameter int DW       = 8,
    parameter int RD_CYC   = 18,
    parameter int TURN_CYC = 7,
    parameter int WP_CYC   = 15,
    parameter int REC_CYC  = 3,
    parameter int CNT_W    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output ctl_t          ctl_d,
    output logic [AW-1:0] addr_d,
    output logic [DW-1:0] wdata_d,
    output logic          cap_en
);

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LAST   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_CYC - 1);

    typedef struct packed {
        phase_e          ph;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
    } seq_s;

    seq_s seq_d, seq_q;
    logic cnt_zero;

    assign cnt_zero = (seq_q.cnt == '0);

    always_comb begin
        seq_d  = seq_q;
        cap_en = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    if (req_write) begin
                        seq_d.ph  = PH_TURN;
                        seq_d.cnt = TURN_LAST;
                    end else begin
                        seq_d.ph  = PH_READ;
                        seq_d.cnt = RD_LAST;
                    end
                end
            end
            PH_READ: begin
                if (cnt_zero) begin
                    cap_en   = 1'b1;
                    seq_d.ph = PH_ACK;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (cnt_zero) begin
                    seq_d.ph  = PH_WPULSE;
                    seq_d.cnt = WP_LAST;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_WPULSE: begin
                if (cnt_zero) begin
                    seq_d.ph  = PH_WREC;
                    seq_d.cnt = REC_LAST;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_WREC: begin
                if (cnt_zero) begin
                    seq_d.ph = PH_ACK;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_ACK:  seq_d.ph = PH_IDLE;
            default: seq_d.ph = PH_IDLE;
        endcase

        // Pin levels for the phase about to start
        ctl_d = CTL_IDLE;
        case (seq_d.ph)
            PH_READ: begin
                ctl_d.cs_n = 1'b0;
                ctl_d.oe_n = 1'b0;
            end
            PH_WPULSE: begin
                ctl_d.cs_n  = 1'b0;
                ctl_d.we_n  = 1'b0;
                ctl_d.dq_oe = 1'b1;
            end
            PH_WREC: ctl_d.dq_oe = 1'b1;
            PH_ACK:  ctl_d.ack   = 1'b1;
            default: ctl_d = CTL_IDLE;
        endcase
        addr_d  = seq_d.addr;
        wdata_d = seq_d.wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cnt: '0, addr: '0, wdata: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/asram_pinreg.sv
module asram_pinreg
    import asram_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_t          ctl_d,
    input  logic [AW-1:0] addr_d,
    input  logic [DW-1:0] dq_d,
    output ctl_t          ctl_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] dq_q
);

    typedef struct packed {
        ctl_t          ctl;
        logic [AW-1:0] addr;
        logic [DW-1:0] dq;
    } pin_s;

    pin_s pin_d, pin_q;

    always_comb begin
        pin_d.ctl  = ctl_d;
        pin_d.addr = addr_d;
        pin_d.dq   = dq_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '{ctl: CTL_IDLE, addr: '0, dq: '0};
        end else begin
            pin_q <= pin_d;
        end
    end

    assign ctl_q  = pin_q.ctl;
    assign addr_q = pin_q.addr;
    assign dq_q   = pin_q.dq;

endmodule

// File: rtl/asram_rdcap.sv
module asram_rdcap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = cap_en ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign dout = data_q;

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
    import asram_pkg::*;
#(
    parameter int AW        = 19,
    parameter int DW        = 8,
    parameter int CLK_NS    = 4,
    parameter int T_RC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_WC_NS   = 70,
    parameter int T_WP_NS   = 55,
    parameter int T_CW_NS   = 60,
    parameter int T_DW_NS   = 30,
    parameter int T_OHZ_NS  = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ack,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    localparam int RD_CYC   = imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS));
    localparam int TURN_CYC = ns2cyc(T_OHZ_NS, CLK_NS);
    localparam int WP_CYC   = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_CW_NS, CLK_NS)),
                                   ns2cyc(T_DW_NS, CLK_NS));
    localparam int WC_CYC   = ns2cyc(T_WC_NS, CLK_NS);
    localparam int REC_CYC  = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
    localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), imax(WP_CYC, REC_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    ctl_t          ctl_d, ctl_q;
    logic [AW-1:0] addr_d;
    logic [DW-1:0] wdata_d;
    logic          cap_en;

    asram_seq #(
        .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC),
        .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ctl_d     (ctl_d),
        .addr_d    (addr_d),
        .wdata_d   (wdata_d),
        .cap_en    (cap_en)
    );

    asram_pinreg #(.AW(AW), .DW(DW)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_d  (ctl_d),
        .addr_d (addr_d),
        .dq_d   (wdata_d),
        .ctl_q  (ctl_q),
        .addr_q (mem_addr),
        .dq_q   (mem_dq_o)
    );

    asram_rdcap #(.DW(DW)) u_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_dq_i),
        .dout   (rsp_rdata)
    );

    assign mem_cs_n  = ctl_q.cs_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_dq_oe = ctl_q.dq_oe;
    assign req_ack   = ctl_q.ack;

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
    parameter int AW       = 19,
    parameter int DW       = 8,
    parameter int TURN_CYC = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          dq_oe,
    input logic          ack,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] dq_o
);

    // Clocks seen with output enable high, saturating
    logic [15:0] oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_cnt <= 16'hFFFF;
        end else if (!oe_n) begin
            oe_hi_cnt <= '0;
        end else if (oe_hi_cnt != 16'hFFFF) begin
            oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    a_r10_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !oe_n));

    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r1_ack_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cs_n && oe_n && we_n && !dq_oe));

    a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> $stable(addr));

    a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !$past(we_n)) |-> $stable(dq_o));

    a_r5_pulse_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && dq_oe));

    a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (oe_hi_cnt >= 16'(TURN_CYC)));

endmodule

bind asram_ctl asram_ctl_chk #(.AW(AW), .DW(DW), .TURN_CYC(TURN_CYC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (mem_cs_n),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n),
    .dq_oe (mem_dq_oe),
    .ack   (req_ack),
    .addr  (mem_addr),
    .dq_o  (mem_dq_o)
);

// File: tb/test_asram_ctl.sv
`timescale 1ns/1ps
module test_asram_ctl;

    // Phase lengths derived here from the requirement formulas at 4 ns clock
    localparam int RDC  = 18;  // max(ceil(70/4), ceil(70/4))
    localparam int TAC  = 7;   // ceil(25/4)
    localparam int WPC  = 15;  // max(ceil(55/4), ceil(60/4), ceil(30/4))
    localparam int RECC = 3;   // max(1, ceil(70/4) - 15)
    localparam int WLAT = TAC + WPC + RECC;
    localparam logic [7:0] BLANK = 8'hA5;  // model content of unwritten cells

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    asram_ctl i_asram_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] model_mem [int];
    logic [7:0] wr_byte;
    logic [18:0] wr_addr;
    int  wr_len = 0, rd_len = 0, oe_gap = 1000;
    bit  dq_oe_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            // R10: memory drives during a read; controller must not drive then
            if (!mem_cs_n && !mem_oe_n && mem_we_n && mem_dq_oe)
                chk(1'b0, "R10 contention", 1, 0);
            // read overlap length, data presented by the model
            if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
                rd_len++;
                mem_dq_i <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : BLANK;
            end else begin
                if (rd_len != 0) chk(rd_len == RDC, "R2 read length", rd_len, RDC);
                rd_len = 0;
                mem_dq_i <= 8'h00;
            end
            // write overlap of chip select and write enable
            if (!mem_cs_n && !mem_we_n) begin
                if (wr_len != 0 && (wr_byte != mem_dq_o))
                    chk(1'b0, "R5 data moved in pulse", mem_dq_o, wr_byte);
                if (!mem_dq_oe) chk(1'b0, "R5 drivers off in pulse", 0, 1);
                wr_len++;
                wr_byte = mem_dq_o;
                wr_addr = mem_addr;
            end else if (wr_len != 0) begin
                chk(wr_len == WPC, "R5 pulse length", wr_len, WPC);
                chk(mem_dq_oe && mem_dq_o == wr_byte, "R7 data held after pulse",
                    {mem_dq_oe, mem_dq_o}, {1'b1, wr_byte});
                model_mem[int'(wr_addr)] = wr_byte;
                wr_len = 0;
            end
            // R4 turnaround interval before drivers turn on
            if (!mem_oe_n) oe_gap = 0;
            else if (oe_gap < 1000) oe_gap++;
            if (mem_dq_oe && !dq_oe_prev)
                chk(oe_gap > TAC, "R4 turnaround", oe_gap - 1, TAC);
            dq_oe_prev = mem_dq_oe;
        end
    end

    // ---------------- scoreboard ----------------
    bit         q_rd [$];
    logic [7:0] q_d  [$];
    logic [7:0] last_rd = 8'h00;
    bit         ack_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ack) begin
                if (ack_prev) chk(1'b0, "R8 ack longer than one clock", 2, 1);
                if (q_rd.size() == 0) begin
                    chk(1'b0, "R9 unexpected ack", 1, 0);
                end else begin
                    bit rd;
                    logic [7:0] exp;
                    rd  = q_rd.pop_front();
                    exp = q_d.pop_front();
                    if (rd) begin
                        chk(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
                        last_rd = exp;
                    end else begin
                        chk(rsp_rdata == last_rd, "R3 read data held over write", rsp_rdata, last_rd);
                    end
                end
            end
            ack_prev = req_ack;
        end
    end

    // ---------------- driver ----------------
    logic [7:0] shadow [int];

    task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d, input bit poke);
        int lat;
        logic [7:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) begin
            shadow[int'(a)] = d;
            exp = d;
        end else begin
            exp = shadow.exists(int'(a)) ? shadow[int'(a)] : BLANK;
        end
        q_rd.push_back(!wr);
        q_d.push_back(exp);
        @(posedge clk);
        @(negedge clk);
        // R9: scramble request fields once accepted
        req_valid = 1'b0; req_write = !wr; req_addr = ~a; req_wdata = ~d;
        lat = 0;
        while (lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (poke && lat == 5) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h0ABCD; req_wdata = 8'h77;
            end else if (poke && lat == 6) begin
                req_valid = 1'b0;
            end
            if (req_ack) break;
        end
        chk(lat == (wr ? WLAT : RDC), wr ? "R8 write latency" : "R8 read latency",
            lat, wr ? WLAT : RDC);
        @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack, "R1 idle after access",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack}, 5'b11100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack, "R1 reset state",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack}, 5'b11100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack, "R1 idle after reset",
            {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack}, 5'b11100);

        do_req(1'b0, 19'h00010, 8'h00, 1'b0);           // read of unwritten cell
        do_req(1'b1, 19'h00000, 8'h5A, 1'b0);           // lowest address, write after read
        do_req(1'b1, 19'h7FFFF, 8'hC3, 1'b0);           // highest address
        do_req(1'b1, 19'h12345, 8'h00, 1'b1);           // R9 poke during access
        do_req(1'b1, 19'h54321, 8'hFF, 1'b0);
        do_req(1'b0, 19'h00000, 8'h00, 1'b0);
        do_req(1'b0, 19'h7FFFF, 8'h00, 1'b1);           // R9 poke during read
        do_req(1'b0, 19'h12345, 8'h00, 1'b0);
        do_req(1'b0, 19'h54321, 8'h00, 1'b0);
        do_req(1'b0, 19'h0ABCD, 8'h00, 1'b0);           // R9: poked address never written
        do_req(1'b1, 19'h00000, 8'hA5 ^ 8'h3C, 1'b0);   // overwrite
        do_req(1'b1, 19'h2AAAA, 8'h96, 1'b0);           // back-to-back writes
        do_req(1'b0, 19'h00000, 8'h00, 1'b0);
        do_req(1'b0, 19'h2AAAA, 8'h00, 1'b0);

        repeat (4) @(negedge clk);
        chk(q_rd.size() == 0, "R9 all requests acknowledged once", q_rd.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule